// File: doc/BRIEF.md
# Serial Port Interrupt Identifier

This unit sits beside the transmit and receive paths of a serial port and decides which of five interrupt causes is reported to the processor. The causes are receive line errors, receive data at or above the FIFO trigger, receive character timeout, transmit FIFO drained, and modem input changes. Each cause has its own rule for how it becomes pending and how it is cleared. The highest-priority enabled cause is encoded into an identification byte, and a level interrupt line is driven from that byte.

Line errors, timeouts, transmit-drained events and modem changes are latched as sticky flags. Each flag is cleared by the register access that services it. Received data is a level condition that follows the FIFO fill compared against the trigger. The FIFO storage, the timeout counter and the register decoder are outside this unit. The decoder supplies one-cycle read and write strobes.

Top module: `sio_intr_ident`

## Requirements
- R1: After synchronous reset the identification byte is 0xC1 and the interrupt line is low.
- R2: Bits 7:6 of the identification byte are always 1 and bits 5:4 are always 0. Bits 3:0 are 0x6 for a line error, 0x4 for received data, 0xC for timeout, 0x2 for transmit drained, 0x0 for modem change, and 0x1 when nothing is reported.
- R3: Enable bit 0 gates received data and timeout. Bit 1 gates transmit drained. Bit 2 gates line errors. Bit 3 gates modem change. A disabled cause is never reported.
- R4: When several enabled causes are pending, the unit reports the first one in this order: line error, received data, timeout, transmit drained, modem change.
- R5: Any line error event latches the line-error cause. A line-status read clears it, except when a new error event arrives in the same cycle as the read.
- R6: Received data is pending while the FIFO level is nonzero and at least the trigger value. It stops being pending as soon as the level falls below the trigger.
- R7: A timeout pulse latches the timeout cause, and a receive-buffer read clears it.
- R8: A transmit-drained event latches its cause. The cause clears on a transmit-holding write, or on an identification read while the byte shows 0x2. A read while another code is shown leaves it pending, and a new event in the same cycle as a clear keeps it pending.
- R9: Any modem change latches the modem cause, and a modem-status read clears it.
- R10: The interrupt line is high exactly when bit 0 of the identification byte is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier_i | input | 4 | Per-cause interrupt enables |
| err_evt_i | input | ERR_W | Line error event pulses (overrun, parity, framing, break) |
| rx_level_i | input | LVL_W | Receive FIFO fill level |
| rx_trig_i | input | LVL_W | Receive FIFO trigger level |
| rx_tmo_i | input | 1 | Character timeout pulse |
| tx_empty_i | input | 1 | Transmit FIFO drained pulse |
| ms_delta_i | input | MS_W | Modem input change pulses |
| lsr_rd_i | input | 1 | Line status register read strobe |
| rbr_rd_i | input | 1 | Receive buffer read strobe |
| iir_rd_i | input | 1 | Identification register read strobe |
| thr_wr_i | input | 1 | Transmit holding register write strobe |
| msr_rd_i | input | 1 | Modem status register read strobe |
| iir_o | output | 8 | Registered identification byte |
| irq_o | output | 1 | Registered level interrupt line |

## Verification
A latched cause can receive a new event in the same cycle as the access that clears it. This covers a transmit-drained pulse arriving with an identification read or holding write, and a new line error arriving with a line-status read. The bench drives both strobes in one cycle and then waits for the byte to settle. The result passes only if the cause is still reported. The bench also sweeps every enable mask against every combination of the five causes, and compares the byte with an arithmetic priority model.

// File: rtl/sio_intr_pkg.sv
package sio_intr_pkg;

  typedef enum logic [3:0] {
    ID_MODEM   = 4'h0,
    ID_NONE    = 4'h1,
    ID_TXEMPTY = 4'h2,
    ID_RXDATA  = 4'h4,
    ID_LINE    = 4'h6,
    ID_RXTMO   = 4'hC
  } intr_id_e;

  // Priority slots, index 0 is highest
  localparam int unsigned NSRC      = 5;
  localparam int unsigned P_LINE    = 0;
  localparam int unsigned P_RXDATA  = 1;
  localparam int unsigned P_RXTMO   = 2;
  localparam int unsigned P_TXEMPTY = 3;
  localparam int unsigned P_MODEM   = 4;

  // Sticky flag slots
  localparam int unsigned NSTICKY  = 4;
  localparam int unsigned S_LINE   = 0;
  localparam int unsigned S_RXTMO  = 1;
  localparam int unsigned S_TXE    = 2;
  localparam int unsigned S_MODEM  = 3;

  localparam logic [1:0] FIFO_ON_BITS = 2'b11;

  function automatic intr_id_e code_of_slot(input int unsigned slot);
    case (slot)
      P_LINE:    return ID_LINE;
      P_RXDATA:  return ID_RXDATA;
      P_RXTMO:   return ID_RXTMO;
      P_TXEMPTY: return ID_TXEMPTY;
      P_MODEM:   return ID_MODEM;
      default:   return ID_NONE;
    endcase
  endfunction

endpackage

// File: rtl/sio_sticky_flag.sv
module sio_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // A new event outranks a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/sio_rx_level_cmp.sv
module sio_rx_level_cmp #(
  parameter int unsigned LVL_W = 5
) (
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] trig_i,
  output logic             hit_o
);
  assign hit_o = (level_i != '0) && (level_i >= trig_i);
endmodule

// File: rtl/sio_intr_encode.sv
module sio_intr_encode
  import sio_intr_pkg::*;
#(
  parameter int unsigned N = NSRC
) (
  input  logic [N-1:0] req_i,
  output intr_id_e     id_o,
  output logic         any_o
);
  always_comb begin
    id_o = ID_NONE;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) id_o = code_of_slot(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/sio_intr_ident.sv
module sio_intr_ident
  import sio_intr_pkg::*;
#(
  parameter int unsigned LVL_W = 5,
  parameter int unsigned ERR_W = 4,
  parameter int unsigned MS_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       ier_i,
  input  logic [ERR_W-1:0] err_evt_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [LVL_W-1:0] rx_trig_i,
  input  logic             rx_tmo_i,
  input  logic             tx_empty_i,
  input  logic [MS_W-1:0]  ms_delta_i,
  input  logic             lsr_rd_i,
  input  logic             rbr_rd_i,
  input  logic             iir_rd_i,
  input  logic             thr_wr_i,
  input  logic             msr_rd_i,
  output logic [7:0]       iir_o,
  output logic             irq_o
);
  logic [NSTICKY-1:0] st_set, st_clr, st_flag;
  logic [NSRC-1:0]    req;
  logic               rx_hit;
  intr_id_e           id_nxt;
  logic               any_nxt;

  always_comb begin
    st_set          = '0;
    st_clr          = '0;
    st_set[S_LINE]  = |err_evt_i;
    st_clr[S_LINE]  = lsr_rd_i;
    st_set[S_RXTMO] = rx_tmo_i;
    st_clr[S_RXTMO] = rbr_rd_i;
    st_set[S_TXE]   = tx_empty_i;
    st_clr[S_TXE]   = thr_wr_i || (iir_rd_i && (iir_o[3:0] == ID_TXEMPTY));
    st_set[S_MODEM] = |ms_delta_i;
    st_clr[S_MODEM] = msr_rd_i;
  end

  for (genvar g = 0; g < NSTICKY; g++) begin : g_flag
    sio_sticky_flag u_flag (
      .clk    (clk),
      .rst    (rst),
      .set_i  (st_set[g]),
      .clr_i  (st_clr[g]),
      .flag_o (st_flag[g])
    );
  end

  sio_rx_level_cmp #(.LVL_W(LVL_W)) u_cmp (
    .level_i (rx_level_i),
    .trig_i  (rx_trig_i),
    .hit_o   (rx_hit)
  );

  always_comb begin
    req            = '0;
    req[P_LINE]    = st_flag[S_LINE]  && ier_i[2];
    req[P_RXDATA]  = rx_hit           && ier_i[0];
    req[P_RXTMO]   = st_flag[S_RXTMO] && ier_i[0];
    req[P_TXEMPTY] = st_flag[S_TXE]   && ier_i[1];
    req[P_MODEM]   = st_flag[S_MODEM] && ier_i[3];
  end

  sio_intr_encode #(.N(NSRC)) u_enc (
    .req_i (req),
    .id_o  (id_nxt),
    .any_o (any_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      iir_o <= {FIFO_ON_BITS, 2'b00, ID_NONE};
      irq_o <= 1'b0;
    end else begin
      iir_o <= {FIFO_ON_BITS, 2'b00, id_nxt};
      irq_o <= any_nxt;
    end
  end
endmodule

// File: rtl/sio_intr_ident_chk.sv
module sio_intr_ident_chk #(
  parameter int unsigned ERR_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       ier_i,
  input logic [ERR_W-1:0] err_evt_i,
  input logic             tx_empty_i,
  input logic             thr_wr_i,
  input logic [7:0]       iir_o,
  input logic             irq_o
);
  assert_irq_level_R10: assert property (@(posedge clk) disable iff (rst)
    irq_o == !iir_o[0]);

  assert_fixed_bits_R2: assert property (@(posedge clk) disable iff (rst)
    (iir_o[7:6] == 2'b11) && (iir_o[5:4] == 2'b00));

  assert_rx_masked_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(ier_i[0]) |-> (iir_o[3:0] != 4'h4) && (iir_o[3:0] != 4'hC));

  assert_line_first_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(|err_evt_i, 2) && $past(ier_i[2])) |-> (iir_o[3:0] == 4'h6));

  assert_txe_write_clear_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(thr_wr_i, 2) && !$past(tx_empty_i, 2) && !$past(tx_empty_i)) |-> (iir_o[3:0] != 4'h2));
endmodule

bind sio_intr_ident sio_intr_ident_chk #(.ERR_W(ERR_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .ier_i      (ier_i),
  .err_evt_i  (err_evt_i),
  .tx_empty_i (tx_empty_i),
  .thr_wr_i   (thr_wr_i),
  .iir_o      (iir_o),
  .irq_o      (irq_o)
);

// File: tb/sio_intr_ident_tb_top.sv
module sio_intr_ident_tb_top;
  localparam int unsigned LVL_W = 5;
  localparam int unsigned ERR_W = 4;
  localparam int unsigned MS_W  = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [3:0]       ier_i = '0;
  logic [ERR_W-1:0] err_evt_i = '0;
  logic [LVL_W-1:0] rx_level_i = '0;
  logic [LVL_W-1:0] rx_trig_i = '0;
  logic             rx_tmo_i = 1'b0;
  logic             tx_empty_i = 1'b0;
  logic [MS_W-1:0]  ms_delta_i = '0;
  logic             lsr_rd_i = 1'b0;
  logic             rbr_rd_i = 1'b0;
  logic             iir_rd_i = 1'b0;
  logic             thr_wr_i = 1'b0;
  logic             msr_rd_i = 1'b0;
  logic [7:0]       iir_o;
  logic             irq_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sio_intr_ident #(.LVL_W(LVL_W), .ERR_W(ERR_W), .MS_W(MS_W)) dut_i (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] exp);
    checks++;
    if (iir_o !== exp || irq_o !== !exp[0]) begin
      errors++;
      $display("FAIL %s: actual iir=%h irq=%b expected iir=%h irq=%b",
               req, iir_o, irq_o, exp, !exp[0]);
    end
  endtask

  function automatic logic [7:0] model(input logic [3:0] en, input logic ls, da, to, te, ms);
    if (en[2] && ls) return 8'hC6;
    if (en[0] && da) return 8'hC4;
    if (en[0] && to) return 8'hCC;
    if (en[1] && te) return 8'hC2;
    if (en[3] && ms) return 8'hC0;
    return 8'hC1;
  endfunction

  task automatic do_reset();
    rst = 1'b1; rx_level_i = '0; rx_trig_i = '0;
    tick(2);
    rst = 1'b0;
    tick(1);
  endtask

  // pend bits: [0] line, [1] rxdata, [2] timeout, [3] txempty, [4] modem
  task automatic make_pending(input logic [4:0] p);
    rx_trig_i  = 5'd4;
    rx_level_i = p[1] ? 5'd4 : 5'd1;
    err_evt_i  = p[0] ? 4'b0001 : '0;
    rx_tmo_i   = p[2];
    tx_empty_i = p[3];
    ms_delta_i = p[4] ? 4'b0100 : '0;
    tick(1);
    err_evt_i = '0; rx_tmo_i = 0; tx_empty_i = 0; ms_delta_i = '0;
    tick(3);
  endtask

  initial begin
    tick(1);
    check("R1 reset byte", 8'hC1);
    do_reset();
    check("R1 after release", 8'hC1);

    // R2 R3 R4 R10 sweep: all enable masks x all cause combinations
    for (int en = 0; en < 16; en++) begin
      for (int p = 0; p < 32; p++) begin
        do_reset();
        ier_i = en[3:0];
        make_pending(p[4:0]);
        check("R2/R3/R4/R10 sweep",
              model(en[3:0], p[0], p[1], p[2], p[3], p[4]));
      end
    end

    ier_i = 4'hF;

    // R5: read clears, coincident error keeps it
    do_reset();
    make_pending(5'b00011);
    check("R5 line error reported", 8'hC6);
    lsr_rd_i = 1; tick(1); lsr_rd_i = 0; tick(3);
    check("R5 cleared by line status read", 8'hC4);
    make_pending(5'b00001);
    lsr_rd_i = 1; err_evt_i = 4'b1000; tick(1);
    lsr_rd_i = 0; err_evt_i = '0; tick(3);
    check("R5 new error with read survives", 8'hC6);

    // R6 level compare
    do_reset();
    rx_trig_i = 5'd8; rx_level_i = 5'd7; tick(3);
    check("R6 below trigger", 8'hC1);
    rx_level_i = 5'd8; tick(3);
    check("R6 at trigger", 8'hC4);
    rx_level_i = 5'd16; tick(3);
    check("R6 above trigger", 8'hC4);
    rx_trig_i = 5'd0; rx_level_i = 5'd0; tick(3);
    check("R6 empty fifo zero trigger", 8'hC1);
    rx_level_i = 5'd1; tick(3);
    check("R6 one entry zero trigger", 8'hC4);
    rx_level_i = 5'd0; tick(3);
    check("R6 drops when drained", 8'hC1);

    // R7 timeout cleared by buffer read
    do_reset();
    make_pending(5'b00100);
    check("R7 timeout reported", 8'hCC);
    rbr_rd_i = 1; tick(1); rbr_rd_i = 0; tick(3);
    check("R7 cleared by buffer read", 8'hC1);

    // R8 transmit drained
    do_reset();
    make_pending(5'b01001);
    check("R8 line outranks drained", 8'hC6);
    iir_rd_i = 1; tick(1); iir_rd_i = 0; tick(3);
    check("R8 id read showing 0x6 keeps drained", 8'hC6);
    lsr_rd_i = 1; tick(1); lsr_rd_i = 0; tick(3);
    check("R8 drained now reported", 8'hC2);
    iir_rd_i = 1; tick(1); iir_rd_i = 0; tick(3);
    check("R8 cleared by id read", 8'hC1);
    make_pending(5'b01000);
    thr_wr_i = 1; tick(1); thr_wr_i = 0; tick(3);
    check("R8 cleared by holding write", 8'hC1);
    make_pending(5'b01000);
    iir_rd_i = 1; tx_empty_i = 1; tick(1);
    iir_rd_i = 0; tx_empty_i = 0; tick(3);
    check("R8 event with id read survives", 8'hC2);
    thr_wr_i = 1; tx_empty_i = 1; tick(1);
    thr_wr_i = 0; tx_empty_i = 0; tick(3);
    check("R8 event with write survives", 8'hC2);

    // R9 modem
    do_reset();
    make_pending(5'b10000);
    check("R9 modem reported", 8'hC0);
    msr_rd_i = 1; tick(1); msr_rd_i = 0; tick(3);
    check("R9 cleared by modem read", 8'hC1);

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule